// File: doc/BRIEF.md
# Inter-Pass Scaling and Clamping for a Separable Inverse Transform

This block conditions the data flowing through a two-pass (row, then column) inverse transform whose 1-D kernels live elsewhere. It has three independent stream paths. The coefficient reader walks a block of up to 64×64 positions in row-major order. It fetches each coefficient from a coefficient store that holds at most 32×32 values and is laid out column-first. It pre-scales the coefficient when the block is 2:1 rectangular and streams it to the row kernel. As it reads each stored coefficient, it writes a zero back to that location, so the store is clean for the next block.

The inter-pass stage takes row-kernel results and applies a rounding right shift. The shift amount depends on the block size. The stage then clamps each result to the column range before the column kernel sees it. The reconstruction stage takes column-kernel results with a matching prediction pixel. It rounds the result down by 16, adds it to the prediction pixel, and clips the sum to the legal pixel range.

The block also presents the clamp limits for both passes, so the kernels can use them. The limits depend on whether the video is 8-bit or of higher depth. Every stream uses valid/ready handshakes with one sample per cycle, and each stage has a single output register.

Top module: `itx_interpass`

## Requirements
- R1: After a `go` pulse while idle, the reader emits exactly W×H samples on the row stream in row-major order, where W = 2^`sz_lw` and H = 2^`sz_lh`. `row_last` is high on the sample at the last column of each row. A sample at row y < 32 and column x < 32 carries the store word at address y + x·min(H,32).
- R2: A sample at a row of 32 or more, or at a column of 32 or more, carries zero. It causes neither a store read nor a clear.
- R3: When one side of the block is exactly twice the other, each stored coefficient is replaced by (c·181+128)>>8, with an arithmetic shift. Other shapes, including 4:1, pass the coefficient unchanged, sign-extended.
- R4: Each store word the reader consumes is cleared exactly once. `clr_we` is high for one handshake with `clr_addr` equal to that word's address. Words outside the top-left min(W,32)×min(H,32) region stay unchanged.
- R5: A `go` pulse while the reader is busy is ignored: the sample count stays W×H.
- R6: With `hi_depth` low, both clamp ranges are [−32768, 32767]. With `hi_depth` high, `row_lo` = (~`bd_max`)<<7 and `col_lo` = (~`bd_max`)<<5, and each upper limit is the bitwise inverse of its lower limit.
- R7: The inter-pass stage outputs clamp((v + r)>>>s, `col_lo`, `col_hi`), where r = (1<<s)>>1. The shift s is set by the block size, as follows:
  - s = 0 for 4×4, 4×8 and 8×4.
  - s = 2 for 16×16, 8×32, 32×8, 32×32, 16×64, 64×16 and 64×64.
  - s = 1 for every other supported size.
- R8: The reconstruction stage outputs clip(p + ((v+8)>>>4), 0, `bd_max`).
- R9: Each stage registers its result one cycle after the input handshake. While its ready input is low, a stage holds its valid output and data stable. A stage accepts input when its output register is empty or is being drained.
- R10: In reset, `row_vld`, `mid_out_vld`, `pix_vld` and `clr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sz_lw | input | 3 | log2 of block width (2..6) |
| sz_lh | input | 3 | log2 of block height (2..6) |
| hi_depth | input | 1 | High for bit depths above 8 |
| bd_max | input | PW | Largest legal pixel value |
| go | input | 1 | Starts a block read when idle |
| rd_addr | output | 2·CAP_LOG | Coefficient store read address |
| rd_data | input | CW | Coefficient store read data, same cycle |
| clr_we | output | 1 | Write zero to the store |
| clr_addr | output | 2·CAP_LOG | Address to clear |
| row_vld | output | 1 | Row stream valid |
| row_rdy | input | 1 | Row stream ready |
| row_data | output | DW | Row stream sample |
| row_last | output | 1 | Last sample of a row |
| row_lo | output | DW | Row-pass clamp minimum |
| row_hi | output | DW | Row-pass clamp maximum |
| col_lo | output | DW | Column-pass clamp minimum |
| col_hi | output | DW | Column-pass clamp maximum |
| mid_in_vld | input | 1 | Row-kernel result valid |
| mid_in_rdy | output | 1 | Row-kernel result ready |
| mid_in_data | input | DW | Row-kernel result |
| mid_out_vld | output | 1 | Shifted/clamped value valid |
| mid_out_rdy | input | 1 | Shifted/clamped value ready |
| mid_out_data | output | DW | Shifted/clamped value |
| rec_in_vld | input | 1 | Column-kernel result valid |
| rec_in_rdy | output | 1 | Column-kernel result ready |
| rec_in_data | input | DW | Column-kernel result |
| rec_pred | input | PW | Prediction pixel for this result |
| pix_vld | output | 1 | Reconstructed pixel valid |
| pix_rdy | input | 1 | Reconstructed pixel ready |
| pix_data | output | PW | Reconstructed pixel |

## Verification
The inter-pass and reconstruction results appear on their outputs one cycle after the input handshake. The first reader sample follows two cycles after `go`: one edge to leave idle and one edge to load the output register. Later samples follow each accepted handshake by one cycle. The bench changes inputs and samples outputs on the falling edge, and it records a handshake only when valid and ready are both high there. Expected values go into a queue at the input handshake and come out at the output handshake, so random back-pressure cannot misalign them. One directed check sets the output ready low and confirms that the registered value is present one cycle after acceptance and still held a cycle later.

// File: rtl/itx_ip_pkg.sv
package itx_ip_pkg;

   typedef enum logic {RD_IDLE, RD_RUN} rd_state_e;

   // Inter-pass rounding shift, chosen by log2(width)+log2(height)
   function automatic logic [2:0] pass_shift(input logic [2:0] lw, input logic [2:0] lh);
      logic [3:0] area;
      area = {1'b0, lw} + {1'b0, lh};
      if (area <= 4'd5)
         return 3'd0;
      else if (area < 4'd8)
         return 3'd1;
      else
         return area[0] ? 3'd1 : 3'd2;
   endfunction

endpackage

// File: rtl/itx_coef_reader.sv
module itx_coef_reader
   import itx_ip_pkg::*;
#(
   parameter int CW      = 20,
   parameter int DW      = 32,
   parameter int CAP_LOG = 5,
   parameter int SZ_LOG  = 6,
   localparam int AW     = 2 * CAP_LOG
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           cfg_lw,
   input  logic [2:0]           cfg_lh,
   input  logic                 start,
   output logic [AW-1:0]        rd_addr,
   input  logic signed [CW-1:0] rd_data,
   output logic                 clr_we,
   output logic [AW-1:0]        clr_addr,
   output logic                 out_vld,
   input  logic                 out_rdy,
   output logic signed [DW-1:0] out_data,
   output logic                 out_last
);

   rd_state_e            st;
   logic [SZ_LOG-1:0]    xc, yc;
   logic [SZ_LOG:0]      w_m1, h_m1;
   logic [2:0]           lsh;
   logic [AW-1:0]        addr;
   logic                 in_range, rect, take, end_col, end_row;
   logic signed [CW+9:0] wide, prod;
   logic signed [DW-1:0] val;

   assign w_m1 = (SZ_LOG+1)'((32'd1 << cfg_lw) - 32'd1);
   assign h_m1 = (SZ_LOG+1)'((32'd1 << cfg_lh) - 32'd1);
   assign lsh  = (cfg_lh > 3'(CAP_LOG)) ? 3'(CAP_LOG) : cfg_lh;
   assign rect = (cfg_lw == cfg_lh + 3'd1) || (cfg_lh == cfg_lw + 3'd1);

   // Store is column-first with a column pitch of min(H, cap)
   assign addr     = AW'(yc[CAP_LOG-1:0]) + (AW'(xc[CAP_LOG-1:0]) << lsh);
   assign in_range = (xc[SZ_LOG-1:CAP_LOG] == '0) && (yc[SZ_LOG-1:CAP_LOG] == '0);

   assign wide = {{10{rd_data[CW-1]}}, rd_data};
   assign prod = wide * 10'sd181 + 10'sd128;

   always_comb begin
      if (!in_range)
         val = '0;
      else if (rect)
         val = {{(DW-CW-2){prod[CW+9]}}, prod[CW+9:8]};
      else
         val = {{(DW-CW){rd_data[CW-1]}}, rd_data};
   end

   assign take     = (st == RD_RUN) && (!out_vld || out_rdy);
   assign end_col  = ({1'b0, xc} == w_m1);
   assign end_row  = ({1'b0, yc} == h_m1);
   assign rd_addr  = addr;
   assign clr_addr = addr;
   assign clr_we   = take && in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= RD_IDLE;
         xc       <= '0;
         yc       <= '0;
         out_vld  <= 1'b0;
         out_data <= '0;
         out_last <= 1'b0;
      end else begin
         if (take) begin
            out_vld  <= 1'b1;
            out_data <= val;
            out_last <= end_col;
         end else if (out_rdy) begin
            out_vld  <= 1'b0;
         end
         case (st)
            RD_IDLE: if (start) begin
               st <= RD_RUN;
               xc <= '0;
               yc <= '0;
            end
            RD_RUN: if (take) begin
               if (end_col) begin
                  xc <= '0;
                  if (end_row) st <= RD_IDLE;
                  else         yc <= yc + 1'b1;
               end else begin
                  xc <= xc + 1'b1;
               end
            end
            default: st <= RD_IDLE;
         endcase
      end
   end

   // R9
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && !out_rdy |=> out_vld && $stable(out_data) && $stable(out_last));

   // R4
   clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> out_vld);

endmodule

// File: rtl/itx_mid_round.sv
module itx_mid_round #(
   parameter int DW   = 32,
   parameter int SH_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SH_W-1:0]      shift,
   input  logic signed [DW-1:0] lo,
   input  logic signed [DW-1:0] hi,
   input  logic                 in_vld,
   output logic                 in_rdy,
   input  logic signed [DW-1:0] in_data,
   output logic                 out_vld,
   input  logic                 out_rdy,
   output logic signed [DW-1:0] out_data
);

   logic signed [DW:0]   ext, rnd, sum, shd, lo_x, hi_x;
   logic signed [DW-1:0] res;

   assign ext  = {in_data[DW-1], in_data};
   assign rnd  = (DW+1)'((32'd1 << shift) >> 1);
   assign sum  = ext + rnd;
   assign shd  = sum >>> shift;
   assign lo_x = {lo[DW-1], lo};
   assign hi_x = {hi[DW-1], hi};

   always_comb begin
      if (shd < lo_x)      res = lo;
      else if (shd > hi_x) res = hi;
      else                 res = shd[DW-1:0];
   end

   assign in_rdy = !out_vld || out_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (in_vld && in_rdy) begin
         out_vld  <= 1'b1;
         out_data <= res;
      end else if (out_rdy) begin
         out_vld  <= 1'b0;
      end
   end

   // R7
   mid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_data >= lo) && (out_data <= hi));

   // R9
   mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && !out_rdy |=> out_vld && $stable(out_data));

endmodule

// File: rtl/itx_recon_add.sv
module itx_recon_add #(
   parameter int DW = 32,
   parameter int PW = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PW-1:0]        bd_max,
   input  logic                 in_vld,
   output logic                 in_rdy,
   input  logic signed [DW-1:0] in_data,
   input  logic [PW-1:0]        pred,
   output logic                 out_vld,
   input  logic                 out_rdy,
   output logic [PW-1:0]        out_data
);

   localparam logic signed [DW+1:0] HALF = (DW+2)'(8);

   logic signed [DW+1:0] ext, rounded, pred_x, bd_x, sum;
   logic [PW-1:0]        res;

   assign ext     = {{2{in_data[DW-1]}}, in_data};
   assign rounded = (ext + HALF) >>> 4;
   assign pred_x  = {{(DW+2-PW){1'b0}}, pred};
   assign bd_x    = {{(DW+2-PW){1'b0}}, bd_max};
   assign sum     = rounded + pred_x;

   always_comb begin
      if (sum < 0)         res = '0;
      else if (sum > bd_x) res = bd_max;
      else                 res = sum[PW-1:0];
   end

   assign in_rdy = !out_vld || out_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (in_vld && in_rdy) begin
         out_vld  <= 1'b1;
         out_data <= res;
      end else if (out_rdy) begin
         out_vld  <= 1'b0;
      end
   end

   // R8
   pix_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> out_data <= bd_max);

   // R9
   pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && !out_rdy |=> out_vld && $stable(out_data));

endmodule

// File: rtl/itx_interpass.sv
module itx_interpass
   import itx_ip_pkg::*;
#(
   parameter int CW      = 20,
   parameter int DW      = 32,
   parameter int PW      = 12,
   parameter int CAP_LOG = 5,
   parameter int SZ_LOG  = 6,
   localparam int AW     = 2 * CAP_LOG
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           sz_lw,
   input  logic [2:0]           sz_lh,
   input  logic                 hi_depth,
   input  logic [PW-1:0]        bd_max,
   input  logic                 go,
   output logic [AW-1:0]        rd_addr,
   input  logic signed [CW-1:0] rd_data,
   output logic                 clr_we,
   output logic [AW-1:0]        clr_addr,
   output logic                 row_vld,
   input  logic                 row_rdy,
   output logic signed [DW-1:0] row_data,
   output logic                 row_last,
   output logic signed [DW-1:0] row_lo,
   output logic signed [DW-1:0] row_hi,
   output logic signed [DW-1:0] col_lo,
   output logic signed [DW-1:0] col_hi,
   input  logic                 mid_in_vld,
   output logic                 mid_in_rdy,
   input  logic signed [DW-1:0] mid_in_data,
   output logic                 mid_out_vld,
   input  logic                 mid_out_rdy,
   output logic signed [DW-1:0] mid_out_data,
   input  logic                 rec_in_vld,
   output logic                 rec_in_rdy,
   input  logic signed [DW-1:0] rec_in_data,
   input  logic [PW-1:0]        rec_pred,
   output logic                 pix_vld,
   input  logic                 pix_rdy,
   output logic [PW-1:0]        pix_data
);

   localparam logic [DW-1:0] S16_MIN = {{(DW-16){1'b1}}, 16'h8000};

   generate
      if (DW < CW + 2 || DW < PW + 8 || DW <= 16) begin : g_bad_dw
         $error("itx_interpass: DW too narrow for CW/PW");
      end
      if (SZ_LOG <= CAP_LOG || SZ_LOG > 7) begin : g_bad_sz
         $error("itx_interpass: SZ_LOG must exceed CAP_LOG and fit 3-bit size codes");
      end
   endgenerate

   logic [DW-1:0] bd_ext;
   logic [2:0]    pass_sh;

   assign bd_ext  = {{(DW-PW){1'b0}}, bd_max};
   assign row_lo  = hi_depth ? (~bd_ext) << 7 : S16_MIN;
   assign col_lo  = hi_depth ? (~bd_ext) << 5 : S16_MIN;
   assign row_hi  = ~row_lo;
   assign col_hi  = ~col_lo;
   assign pass_sh = pass_shift(sz_lw, sz_lh);

   itx_coef_reader #(
      .CW(CW), .DW(DW), .CAP_LOG(CAP_LOG), .SZ_LOG(SZ_LOG)
   ) u_reader (
      .clk(clk), .rst_n(rst_n), .cfg_lw(sz_lw), .cfg_lh(sz_lh), .start(go),
      .rd_addr(rd_addr), .rd_data(rd_data), .clr_we(clr_we), .clr_addr(clr_addr),
      .out_vld(row_vld), .out_rdy(row_rdy), .out_data(row_data), .out_last(row_last)
   );

   itx_mid_round #(.DW(DW), .SH_W(3)) u_mid (
      .clk(clk), .rst_n(rst_n), .shift(pass_sh), .lo(col_lo), .hi(col_hi),
      .in_vld(mid_in_vld), .in_rdy(mid_in_rdy), .in_data(mid_in_data),
      .out_vld(mid_out_vld), .out_rdy(mid_out_rdy), .out_data(mid_out_data)
   );

   itx_recon_add #(.DW(DW), .PW(PW)) u_rec (
      .clk(clk), .rst_n(rst_n), .bd_max(bd_max),
      .in_vld(rec_in_vld), .in_rdy(rec_in_rdy), .in_data(rec_in_data), .pred(rec_pred),
      .out_vld(pix_vld), .out_rdy(pix_rdy), .out_data(pix_data)
   );

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !row_vld && !mid_out_vld && !pix_vld && !clr_we);

endmodule

// File: tb/tb_itx_interpass.sv
module tb_itx_interpass;
   localparam int CW = 20, DW = 32, PW = 12, CAP_LOG = 5, SZ_LOG = 6;
   localparam int AW = 2 * CAP_LOG, NMEM = 1 << AW;

   logic clk = 0, rst_n = 0;
   logic [2:0] sz_lw = 2, sz_lh = 2;
   logic hi_depth = 0, go = 0;
   logic [PW-1:0] bd_max = 255;
   logic [AW-1:0] rd_addr, clr_addr;
   logic signed [CW-1:0] rd_data;
   logic clr_we, row_vld, row_last, row_rdy = 0;
   logic signed [DW-1:0] row_data, row_lo, row_hi, col_lo, col_hi;
   logic mid_in_vld = 0, mid_in_rdy, mid_out_vld, mid_out_rdy = 0;
   logic signed [DW-1:0] mid_in_data = 0, mid_out_data;
   logic rec_in_vld = 0, rec_in_rdy, pix_vld, pix_rdy = 0;
   logic signed [DW-1:0] rec_in_data = 0;
   logic [PW-1:0] rec_pred = 0, pix_data;

   logic [CW-1:0] mem [NMEM];
   int refm [NMEM];
   int n_vec = 0, n_bad = 0, clr_cnt = 0, cyc_all = 0;
   bit wd_hit = 0;
   longint q [$];

   always #5 clk = ~clk;
   always @(posedge clk) begin
      cyc_all <= cyc_all + 1;
      if (cyc_all > 150000) wd_hit <= 1;
      if (clr_we) begin
         mem[clr_addr] <= '0;
         clr_cnt <= clr_cnt + 1;
      end
   end
   assign rd_data = mem[rd_addr];

   itx_interpass #(.CW(CW), .DW(DW), .PW(PW), .CAP_LOG(CAP_LOG), .SZ_LOG(SZ_LOG)) dut (
      .clk(clk), .rst_n(rst_n), .sz_lw(sz_lw), .sz_lh(sz_lh), .hi_depth(hi_depth),
      .bd_max(bd_max), .go(go), .rd_addr(rd_addr), .rd_data(rd_data), .clr_we(clr_we),
      .clr_addr(clr_addr), .row_vld(row_vld), .row_rdy(row_rdy), .row_data(row_data),
      .row_last(row_last), .row_lo(row_lo), .row_hi(row_hi), .col_lo(col_lo), .col_hi(col_hi),
      .mid_in_vld(mid_in_vld), .mid_in_rdy(mid_in_rdy), .mid_in_data(mid_in_data),
      .mid_out_vld(mid_out_vld), .mid_out_rdy(mid_out_rdy), .mid_out_data(mid_out_data),
      .rec_in_vld(rec_in_vld), .rec_in_rdy(rec_in_rdy), .rec_in_data(rec_in_data),
      .rec_pred(rec_pred), .pix_vld(pix_vld), .pix_rdy(pix_rdy), .pix_data(pix_data)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int shift_of(input int w, input int h);
      if ((w == 4 && h == 4) || (w == 4 && h == 8) || (w == 8 && h == 4)) return 0;
      if ((w == 16 && h == 16) || (w == 8 && h == 32) || (w == 32 && h == 8) ||
          (w == 32 && h == 32) || (w == 16 && h == 64) || (w == 64 && h == 16) ||
          (w == 64 && h == 64)) return 2;
      return 1;
   endfunction

   function automatic longint lim_lo(input bit hd, input int bd, input int sh7);
      return hd ? -(longint'(bd) + 1) * (longint'(1) << sh7) : -32768;
   endfunction

   function automatic longint clampl(input longint v, input longint lo, input longint hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   task automatic run_reader(input int lw, input int lh, input bit restart);
      int w = 1 << lw, h = 1 << lh;
      int sh = (h < 32) ? h : 32;
      int sw = (w < 32) ? w : 32;
      bit rect = (lw == lh + 1) || (lh == lw + 1);
      int got = 0, cyc = 0, extra = 0, bad_mem = 0, clr0;
      @(negedge clk);
      sz_lw = 3'(lw); sz_lh = 3'(lh);
      for (int i = 0; i < NMEM; i++) begin
         int r = int'($urandom % (1 << CW)) - (1 << (CW - 1));
         refm[i] = r;
         mem[i] = CW'(r);
      end
      clr0 = clr_cnt;
      go = 1;
      @(negedge clk);
      go = 0;
      while (got < w * h && cyc < 30000 && !wd_hit) begin
         row_rdy = ($urandom % 4) != 0;
         go = restart && (cyc == 3);
         #1;
         if (row_vld && row_rdy) begin
            int y = got / w, x = got % w;
            longint e = 0;
            string tag = "R2";
            if (y < 32 && x < 32) begin
               e = refm[y + x * sh];
               tag = "R1";
               if (rect) begin
                  e = (e * 181 + 128) >>> 8;
                  tag = "R3";
               end
            end
            chk(tag, longint'(row_data), e);
            chk("R1 last", longint'(row_last), longint'(x == w - 1));
            got++;
         end
         @(negedge clk);
         cyc++;
      end
      go = 0;
      row_rdy = 1;
      for (int k = 0; k < 8; k++) begin
         #1;
         if (row_vld) extra++;
         @(negedge clk);
      end
      chk("R5 sample count", got + extra, w * h);
      for (int i = 0; i < NMEM; i++)
         if (mem[i] != ((i < sh * sw) ? '0 : CW'(refm[i]))) bad_mem++;
      chk("R4 store contents", bad_mem, 0);
      chk("R4 clear count", clr_cnt - clr0, sh * sw);
   endtask

   function automatic logic [DW-1:0] pick(input int k);
      if (k % 50 == 0) return 32'h7fffffff;
      if (k % 50 == 1) return 32'h80000000;
      if (k % 3 == 0)  return $urandom;
      return DW'(int'($urandom % 300000) - 150000);
   endfunction

   task automatic run_mid(input bit hd, input int bd, input int lw, input int lh, input int n);
      int sent = 0, recv = 0, cyc = 0;
      int sh = shift_of(1 << lw, 1 << lh);
      longint clo = lim_lo(hd, bd, 5), chi = -clo - 1;
      longint rlo = lim_lo(hd, bd, 7);
      @(negedge clk);
      hi_depth = hd; bd_max = PW'(bd); sz_lw = 3'(lw); sz_lh = 3'(lh);
      #1;
      chk("R6 row_lo", longint'(row_lo), rlo);
      chk("R6 row_hi", longint'(row_hi), -rlo - 1);
      chk("R6 col_lo", longint'(col_lo), clo);
      chk("R6 col_hi", longint'(col_hi), chi);
      q.delete();
      while (recv < n && cyc < 20000 && !wd_hit) begin
         bit acc;
         if (!mid_in_vld && sent < n && ($urandom % 3) != 0) begin
            mid_in_vld = 1;
            mid_in_data = pick(sent);
         end
         mid_out_rdy = ($urandom % 4) != 0;
         #1;
         acc = mid_in_vld && mid_in_rdy;
         if (acc) begin
            q.push_back(clampl((longint'(mid_in_data) + ((longint'(1) << sh) >>> 1)) >>> sh,
                               clo, chi));
            sent++;
         end
         if (mid_out_vld && mid_out_rdy) begin
            chk("R7", longint'(mid_out_data), q.pop_front());
            recv++;
         end
         @(negedge clk);
         cyc++;
         if (acc) mid_in_vld = 0;
      end
      mid_out_rdy = 0;
   endtask

   task automatic run_rec(input int bd, input int n);
      int sent = 0, recv = 0, cyc = 0;
      @(negedge clk);
      bd_max = PW'(bd);
      q.delete();
      while (recv < n && cyc < 20000 && !wd_hit) begin
         bit acc;
         if (!rec_in_vld && sent < n && ($urandom % 3) != 0) begin
            rec_in_vld = 1;
            rec_in_data = (sent % 7 == 0) ? pick(sent) : DW'(int'($urandom % 40000) - 20000);
            rec_pred = PW'($urandom % (bd + 1));
         end
         pix_rdy = ($urandom % 4) != 0;
         #1;
         acc = rec_in_vld && rec_in_rdy;
         if (acc) begin
            q.push_back(clampl(longint'(rec_pred) + ((longint'(rec_in_data) + 8) >>> 4),
                               0, bd));
            sent++;
         end
         if (pix_vld && pix_rdy) begin
            chk("R8", longint'(pix_data), q.pop_front());
            recv++;
         end
         @(negedge clk);
         cyc++;
         if (acc) rec_in_vld = 0;
      end
      pix_rdy = 0;
   endtask

   initial begin
      int seed_sink;
      seed_sink = $urandom(20240611);
      repeat (3) @(negedge clk);
      chk("R10 row_vld", longint'(row_vld), 0);
      chk("R10 mid_out_vld", longint'(mid_out_vld), 0);
      chk("R10 pix_vld", longint'(pix_vld), 0);
      chk("R10 clr_we", longint'(clr_we), 0);
      rst_n = 1;
      @(negedge clk);

      // R9 directed: one-cycle latency then hold under back-pressure (4x4, shift 0)
      mid_in_vld = 1; mid_in_data = 100; mid_out_rdy = 0;
      @(negedge clk);
      mid_in_vld = 0;
      chk("R9 latency", longint'(mid_out_vld), 1);
      chk("R9 data", longint'(mid_out_data), 100);
      @(negedge clk);
      chk("R9 hold", longint'(mid_out_vld), 1);
      chk("R9 hold data", longint'(mid_out_data), 100);
      mid_out_rdy = 1;
      @(negedge clk);
      chk("R9 drain", longint'(mid_out_vld), 0);
      mid_out_rdy = 0;

      run_reader(2, 2, 1);   // 4x4, second go while busy
      run_reader(3, 4, 0);   // 8x16 rectangular
      run_reader(4, 2, 0);   // 16x4, 4:1 not scaled
      run_reader(5, 4, 0);   // 32x16 rectangular
      run_reader(6, 5, 0);   // 64x32 rectangular, columns beyond cap
      run_reader(4, 6, 0);   // 16x64, rows beyond cap
      run_reader(6, 6, 1);   // 64x64

      run_mid(0, 255, 2, 2, 300);
      run_mid(1, 1023, 3, 3, 300);
      run_mid(1, 4095, 4, 4, 300);
      run_mid(0, 255, 6, 6, 300);
      run_mid(1, 1023, 5, 6, 300);
      run_mid(1, 4095, 2, 4, 200);

      run_rec(255, 300);
      run_rec(1023, 300);
      run_rec(4095, 300);

      if (wd_hit) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 150000);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule